// File: doc/BRIEF.md
# Open-Drain I2C Bit Engine

This block turns single-primitive requests into I2C bus conditions on two open-drain drive-low enables, one for the clock line and one for the data line. A separate input carries the sampled level of the data line. A higher-level sequencer builds whole transfers from these primitives: start, stop, byte write, byte read, send acknowledge, send not-acknowledge and check acknowledge. The engine returns the received byte and the acknowledge result.

An enable that is high pulls its line low. An enable that is low releases the line, and an external pull-up takes it high. Every timed phase of a primitive lasts a programmable number of clock cycles, called the quarter period Q. Q is taken from `quarter_i` when the request is accepted, and a value of 0 counts as 1. The acknowledge check does not use Q. Instead it polls the receive line once per clock for a bounded number of cycles. The clock line is left driven low if the slave acknowledged, and left released if it did not. Clock stretching and arbitration are not handled.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, both enables are low (lines released), `busy_o`, `done_o` and `ack_o` are 0, and `rd_data_o` is 0.
- R2: A request is taken only while `busy_o` is 0. Opcodes on `req_op_i`: 0 start, 1 stop, 2 write, 3 read, 4 send ACK, 5 send NAK, 6 check ACK. Opcode 7 is ignored, and so is any request made while busy: neither raises `busy_o` nor produces a `done_o`.
- R3: Every primitive ends with a `done_o` pulse of exactly one cycle. `busy_o` is 0 in that cycle. Counted from the accepting clock edge to the `done_o` cycle, the durations are: start 3Q, stop 4Q, write 25Q, read 16Q, send ACK or NAK 4Q.
- R4: Start releases both lines, then drives data low while the clock is released, then drives the clock low. It ends with both enables high.
- R5: Stop drives the clock low, then drives data low, then releases the clock, then releases data while the clock is released. It ends with both enables low.
- R6: A write sends `req_data_i` MSB first. Data changes only while the clock is driven low. The write ends with the clock enable high and the data enable low.
- R7: A read samples `sda_rx_i` at the end of each of 8 clock-released phases. The first sample lands in the MSB of `rd_data_o`. The data enable stays low throughout, and the read ends with the clock enable high.
- R8: Send ACK holds data driven low across one clock pulse. Send NAK holds data released across the pulse. Both end with the clock enable high and the data enable low.
- R9: Check ACK releases the clock and samples `sda_rx_i` once per clock, up to 16 times. On a low sample, `ack_o` becomes 1, the clock enable goes high, and `done_o` follows one cycle after the accepting edge if the first sample is low. With 16 high samples, `ack_o` becomes 0, the clock stays released, and `done_o` follows after 16 cycles.
- R10: While idle, both enables and `rd_data_o` hold their values.
- R11: `ack_o` changes only in the cycle in which a check ACK completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Primitive opcode |
| req_data_i | input | 8 | Byte to write |
| quarter_i | input | 8 | Quarter period in clock cycles |
| sda_rx_i | input | 1 | Sampled data line level |
| busy_o | output | 1 | Primitive in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Received byte |
| ack_o | output | 1 | Result of the last acknowledge check |
| scl_oe_o | output | 1 | Clock line drive-low enable |
| sda_oe_o | output | 1 | Data line drive-low enable |

## Verification
The bench counts data-line transitions that occur while the clock is released. A start and a stop each have exactly one such transition, in opposite directions. A write that moved data at the wrong time would add extra transitions, and a start or stop in the wrong order would produce none. A bus-side monitor captures the data line on each clock release. This catches bytes sent LSB first and an ACK/NAK level that is swapped. The acknowledge check is run with and without a responding slave. A design that confused the two would leave the clock at the wrong level or take the full 16 polls when it should finish at once. Reserved opcodes and requests made while busy are driven as well. A design that took either would emit an extra done pulse or alter the bus sequence.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_STOP   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_TX_ACK = 3'd4,
    OP_TX_NAK = 3'd5,
    OP_CHECK  = 3'd6,
    OP_RSVD   = 3'd7
  } i2c_op_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ST_REL, S_ST_SDA, S_ST_SCL,
    S_SP_SCL, S_SP_SDA, S_SP_SCLR, S_SP_SDAR,
    S_WR_LOW, S_WR_DAT, S_WR_HIGH, S_WR_REL,
    S_RD_HIGH, S_RD_LOW,
    S_AK_DAT, S_AK_HIGH, S_AK_LOW, S_AK_REL,
    S_CHK
  } eng_state_e;

endpackage

// File: rtl/i2c_qtimer.sv
module i2c_qtimer #(
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [QW-1:0] q_i,
  input  logic          en_i,
  output logic          tick_o
);

  logic [QW-1:0] q_lat, cnt_q, q_eff;

  // zero quarter period behaves as one cycle
  assign q_eff  = (q_i == '0) ? QW'(1) : q_i;
  assign tick_o = en_i && (cnt_q <= QW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_lat <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      q_lat <= q_eff;
      cnt_q <= q_eff;
    end else if (en_i) begin
      cnt_q <= tick_o ? q_lat : cnt_q - QW'(1);
    end
  end

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          tx_shift_i,
  input  logic          rx_shift_i,
  input  logic          rx_bit_i,
  output logic          tx_msb_o,
  output logic [DW-1:0] rx_byte_o
);

  logic [DW-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)          tx_q <= data_i;
      else if (tx_shift_i) tx_q <= {tx_q[DW-2:0], 1'b0};
      if (rx_shift_i)      rx_q <= {rx_q[DW-2:0], rx_bit_i};
    end
  end

  assign tx_msb_o  = tx_q[DW-1];
  assign rx_byte_o = rx_q;

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DW    = 8,
  parameter int QW    = 8,
  parameter int POLLS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    req_op_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [QW-1:0] quarter_i,
  input  logic          sda_rx_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          ack_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DW - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLLS - 1);

  eng_state_e    state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic          done_q, done_d, ack_q;
  logic          ack_set, ack_val;
  logic          accept, tick, timed, tx_msb, tx_shift, rx_shift;

  assign accept = (state_q == S_IDLE) && req_valid_i && (req_op_i != OP_RSVD);
  assign timed  = (state_q != S_IDLE) && (state_q != S_CHK);

  i2c_qtimer #(.QW(QW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .q_i    (quarter_i),
    .en_i   (timed),
    .tick_o (tick)
  );

  i2c_byte_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .data_i     (req_data_i),
    .tx_shift_i (tx_shift),
    .rx_shift_i (rx_shift),
    .rx_bit_i   (sda_rx_i),
    .tx_msb_o   (tx_msb),
    .rx_byte_o  (rd_data_o)
  );

  // sequencing
  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    poll_d   = poll_q;
    done_d   = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    ack_set  = 1'b0;
    ack_val  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        bit_d  = '0;
        poll_d = '0;
        if (accept) begin
          unique case (req_op_i)
            OP_START:  state_d = S_ST_REL;
            OP_STOP:   state_d = S_SP_SCL;
            OP_WRITE:  state_d = S_WR_LOW;
            OP_READ:   state_d = S_RD_HIGH;
            OP_CHECK:  state_d = S_CHK;
            default:   state_d = S_AK_DAT;
          endcase
        end
      end
      S_ST_REL:  if (tick) state_d = S_ST_SDA;
      S_ST_SDA:  if (tick) state_d = S_ST_SCL;
      S_SP_SCL:  if (tick) state_d = S_SP_SDA;
      S_SP_SDA:  if (tick) state_d = S_SP_SCLR;
      S_SP_SCLR: if (tick) state_d = S_SP_SDAR;
      S_WR_LOW:  if (tick) state_d = S_WR_DAT;
      S_WR_DAT:  if (tick) state_d = S_WR_HIGH;
      S_WR_HIGH: if (tick) begin
        if (bit_q == LAST_BIT) state_d = S_WR_REL;
        else begin
          bit_d    = bit_q + BW'(1);
          tx_shift = 1'b1;
          state_d  = S_WR_LOW;
        end
      end
      S_RD_HIGH: if (tick) begin
        rx_shift = 1'b1;
        state_d  = S_RD_LOW;
      end
      S_RD_LOW: if (tick) begin
        if (bit_q == LAST_BIT) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          bit_d   = bit_q + BW'(1);
          state_d = S_RD_HIGH;
        end
      end
      S_AK_DAT:  if (tick) state_d = S_AK_HIGH;
      S_AK_HIGH: if (tick) state_d = S_AK_LOW;
      S_AK_LOW:  if (tick) state_d = S_AK_REL;
      S_ST_SCL, S_SP_SDAR, S_WR_REL, S_AK_REL: if (tick) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end
      S_CHK: begin
        if (!sda_rx_i) begin
          ack_set = 1'b1;
          ack_val = 1'b1;
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (poll_q == LAST_POLL) begin
          ack_set = 1'b1;
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          poll_d = poll_q + PW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // line levels applied on entry to each phase
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    if (state_d != state_q) begin
      unique case (state_d)
        S_ST_REL:  begin scl_d = 1'b0; sda_d = 1'b0; end
        S_ST_SDA:  sda_d = 1'b1;
        S_ST_SCL:  scl_d = 1'b1;
        S_SP_SCL:  scl_d = 1'b1;
        S_SP_SDA:  sda_d = 1'b1;
        S_SP_SCLR: scl_d = 1'b0;
        S_SP_SDAR: sda_d = 1'b0;
        S_WR_LOW:  scl_d = 1'b1;
        S_WR_DAT:  sda_d = ~tx_msb;
        S_WR_HIGH: scl_d = 1'b0;
        S_WR_REL:  begin scl_d = 1'b1; sda_d = 1'b0; end
        S_RD_HIGH: begin scl_d = 1'b0; sda_d = 1'b0; end
        S_RD_LOW:  scl_d = 1'b1;
        S_AK_DAT:  sda_d = (req_op_i == OP_TX_ACK);
        S_AK_HIGH: scl_d = 1'b0;
        S_AK_LOW:  scl_d = 1'b1;
        S_AK_REL:  sda_d = 1'b0;
        S_CHK:     scl_d = 1'b0;
        S_IDLE:    if (ack_set && ack_val) scl_d = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bit_q   <= '0;
      poll_q  <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      poll_q  <= poll_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      if (ack_set) ack_q <= ack_val;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign ack_o    = ack_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [2:0]    req_op_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] rd_data_o,
  input logic          ack_o,
  input logic          scl_oe_o,
  input logic          sda_oe_o
);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_rsvd_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i == 3'd7) |=> (!busy_o && !done_o));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |->
      ($stable(scl_oe_o) && $stable(sda_oe_o) && $stable(rd_data_o)));

  assert_ack_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ack_o));

endmodule

bind i2c_bit_engine i2c_bit_engine_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_data_o   (rd_data_o),
  .ack_o       (ack_o),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o)
);

// File: tb/sim_i2c_bit_engine.sv
module sim_i2c_bit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {op, data, quarter, cycles, end scl_oe, end sda_oe}
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 4'd2, 8'd6,  1'b1, 1'b1},
    {3'd2, 8'hA5, 4'd1, 8'd25, 1'b1, 1'b0},
    {3'd6, 8'h01, 4'd1, 8'd1,  1'b1, 1'b0},
    {3'd2, 8'h3C, 4'd3, 8'd75, 1'b1, 1'b0},
    {3'd6, 8'h00, 4'd2, 8'd16, 1'b0, 1'b0},
    {3'd0, 8'h00, 4'd1, 8'd3,  1'b1, 1'b1},
    {3'd3, 8'h96, 4'd2, 8'd32, 1'b1, 1'b0},
    {3'd4, 8'h00, 4'd1, 8'd4,  1'b1, 1'b0},
    {3'd3, 8'h5B, 4'd0, 8'd16, 1'b1, 1'b0},
    {3'd5, 8'h00, 4'd2, 8'd8,  1'b1, 1'b0},
    {3'd1, 8'h00, 4'd1, 8'd4,  1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_data = '0;
  logic [7:0] quarter = 8'd1;
  logic       busy, done, ack, scl_oe, sda_oe, sda_rx;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  // bus-side model
  logic       rd_active = 1'b0;
  logic       chk_ack = 1'b0;
  logic [7:0] rd_byte = '0;
  int         rd_idx = 0;
  logic       prev_scl = 1'b0, prev_sda = 1'b0;
  int         hi_rise = 0, hi_fall = 0, ncap = 0;
  logic [7:0] cap = '0;
  logic       slave_drv;

  assign slave_drv = rd_active ? rd_byte[3'(7 - rd_idx)] : !chk_ack;
  assign sda_rx    = sda_oe ? 1'b0 : slave_drv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bit_engine u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_data_i  (req_data),
    .quarter_i   (quarter),
    .sda_rx_i    (sda_rx),
    .busy_o      (busy),
    .done_o      (done),
    .rd_data_o   (rd_data),
    .ack_o       (ack),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe)
  );

  always @(negedge clk) begin
    if (sda_oe != prev_sda && !scl_oe && !prev_scl) begin
      if (sda_oe) hi_rise <= hi_rise + 1;
      else        hi_fall <= hi_fall + 1;
    end
    if (prev_scl && !scl_oe) begin
      cap  <= {cap[6:0], ~sda_oe};
      ncap <= ncap + 1;
    end
    if (!rd_active) rd_idx <= 0;
    else if (!prev_scl && scl_oe && rd_idx < 7) rd_idx <= rd_idx + 1;
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] data,
                        input logic [7:0] q, output int cyc);
    @(negedge clk);
    rd_byte   = data;
    rd_active = (op == 3'd3);
    chk_ack   = (op == 3'd6) && data[0];
    req_op    = op;
    req_data  = data;
    quarter   = q;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 2000) check(1'b0, "R3 watchdog", cyc, 0);
    rd_active = 1'b0;
    chk_ack   = 1'b0;
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!scl_oe && !sda_oe && !busy && !done && !ack && rd_data == 8'h00,
          "R1 reset", {scl_oe, sda_oe, busy, done, ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [7:0] d;
      int r0, f0, c0;
      op = VEC[i][24:22];
      d  = VEC[i][21:14];
      r0 = hi_rise; f0 = hi_fall; c0 = ncap;
      run_op(op, d, {4'd0, VEC[i][13:10]}, cyc);
      check(cyc == int'(VEC[i][9:2]), "R3 duration", cyc, int'(VEC[i][9:2]));
      check(!busy, "R3 busy low at done", busy, 0);
      check({scl_oe, sda_oe} == VEC[i][1:0], "R4-8 end lines",
            {scl_oe, sda_oe}, VEC[i][1:0]);
      unique case (op)
        3'd0: check(hi_rise - r0 == 1 && hi_fall == f0, "R4 start order",
                    hi_rise - r0, 1);
        3'd1: check(hi_fall - f0 == 1 && hi_rise == r0, "R5 stop order",
                    hi_fall - f0, 1);
        3'd2: begin
          check(hi_rise == r0 && hi_fall == f0, "R6 data stable while clock high",
                hi_rise - r0 + hi_fall - f0, 0);
          check(ncap - c0 == 8 && cap == d, "R6 write byte", cap, d);
        end
        3'd3: begin
          check(rd_data == d, "R7 read byte", rd_data, d);
          check(hi_rise == r0 && hi_fall == f0, "R7 data released",
                hi_rise - r0 + hi_fall - f0, 0);
        end
        3'd4: check(ncap - c0 == 1 && cap[0] == 1'b0, "R8 ack level", cap[0], 0);
        3'd5: check(ncap - c0 == 1 && cap[0] == 1'b1, "R8 nak level", cap[0], 1);
        default: check(ack == d[0], "R9 ack result", ack, d[0]);
      endcase
      @(negedge clk);
      check(!done, "R3 single-cycle done", done, 0);
    end

    // R11: ack_o survives other primitives
    run_op(3'd6, 8'h01, 8'd1, cyc);
    check(ack, "R9 ack seen", ack, 1);
    run_op(3'd0, 8'h00, 8'd1, cyc);
    check(ack, "R11 ack held across start", ack, 1);
    run_op(3'd2, 8'hFF, 8'd1, cyc);
    check(ack, "R11 ack held across write", ack, 1);

    // R2: reserved opcode ignored
    begin
      int seen = 0;
      @(negedge clk);
      req_op = 3'd7; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (busy || done) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R2 reserved opcode", seen, 0);
      check(scl_oe && !sda_oe, "R2 lines unchanged", {scl_oe, sda_oe}, 2);
    end

    // R2: request while busy ignored
    begin
      int dones = 0, first = -1;
      @(negedge clk);
      req_op = 3'd1; quarter = 8'd4; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 60; k++) begin
        if (k == 3) begin req_op = 3'd2; req_data = 8'h00; req_valid = 1'b1; end
        if (k == 4) req_valid = 1'b0;
        if (done) begin dones++; if (first < 0) first = k; end
        @(negedge clk);
      end
      check(dones == 1, "R2 busy request ignored", dones, 1);
      check(first == 16, "R3 stop duration", first, 16);
      check(!scl_oe && !sda_oe, "R5 stop end", {scl_oe, sda_oe}, 0);
    end

    // R10: idle hold
    begin
      logic [9:0] snap;
      snap = {scl_oe, sda_oe, rd_data};
      repeat (20) @(negedge clk);
      check({scl_oe, sda_oe, rd_data} == snap, "R10 idle hold",
            {scl_oe, sda_oe, rd_data}, snap);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule